// File: doc/BRIEF.md
# Write Completion Status Readback

This block sits in the read data path of a byte-wide non-volatile memory. While the internal programming cycle runs, it replaces parts of the array data with status bits, so a host can tell when the write has finished without a separate status pin. It takes the chip, output and write enables (all active low), the read address, the array read data, a busy flag from the write engine, and the address and data of the last byte loaded. It produces an 8-bit output bus and an enable that controls the external tri-state buffer.

Two status methods are provided together. The first is complement polling: reading the last loaded location returns the inverse of that byte's top bit until programming ends. The second is a toggling bit: bit 6 changes value on every new read access while busy. A read access is counted once, when the combined read-enable term becomes active. A new access therefore needs the output enable, the chip enable, or both to be released and asserted again. Once busy drops, the whole byte reads back as true array data and bit 6 stops changing.

Top module: `wr_status_readback`

## Requirements
- R1: `dq_oe` is 1 only when `ce_n`=0, `oe_n`=0 and `we_n`=1. In every other case `dq_oe` is 0 and `dq_out` is 0x00.
- R2: While `busy`=1 and `addr` equals `last_addr`, `dq_out[7]` is the inverse of `last_data[7]`.
- R3: While `busy`=1 and `addr` differs from `last_addr`, `dq_out[7]` equals `array_rdata[7]`.
- R4: While `busy`=1, each new read access shows `dq_out[6]` with the opposite value from the previous access. The first value is not specified.
- R5: `dq_out[6]` stays constant for the whole of one continuous read access, however many cycles it lasts.
- R6: A new access begins when the read-enable term becomes active. It can be started by releasing and reasserting either `oe_n` or `ce_n`. A period with `we_n`=0 is not an access and does not advance the toggle.
- R7: While `busy`=1, `dq_out[5:0]` equals `array_rdata[5:0]`.
- R8: While `busy`=0, `dq_out` equals `array_rdata` in all bits, and repeated reads do not change bit 6.
- R9: Polling takes effect in the same cycle that `busy` is seen. This also holds when `busy` rises during a read access that is already open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Read address |
| array_rdata | input | DATA_W | Data read from the array at `addr` |
| busy | input | 1 | Programming cycle in progress |
| last_addr | input | ADDR_W | Address of the last byte loaded |
| last_data | input | DATA_W | Data of the last byte loaded |
| dq_out | output | DATA_W | Read data or status |
| dq_oe | output | 1 | Drive enable for the external tri-state buffer |

## Verification
The bench holds one read open for many cycles. A design that counted levels instead of access starts would flip bit 6 in the middle of that read. It also starts accesses through the chip enable alone and through the output enable alone, and inserts a period with write enable low. A design that ignored one of the enables, or counted that period as an access, would either miss an alternation or show an extra one. Busy is raised during an open read to catch a design that only latches status when an access starts. Reads on an address other than the last loaded one catch a design that complements bit 7 everywhere.

// File: rtl/wsr_pkg.sv
package wsr_pkg;

    // Where each output bit takes its value from
    typedef enum logic [1:0] {
        SRC_ARRAY  = 2'd0,
        SRC_POLL   = 2'd1,
        SRC_TOGGLE = 2'd2
    } bit_src_e;

    // Read access qualifiers produced by the enable decoder
    typedef struct packed {
        logic en;     // read term active this cycle
        logic start;  // first cycle of a new access
    } rd_evt_t;

    function automatic bit_src_e pick_src(input int idx, input int poll_idx,
                                          input int tog_idx, input logic busy,
                                          input logic hit);
        bit_src_e s;
        s = SRC_ARRAY;
        if (busy) begin
            if (idx == tog_idx)
                s = SRC_TOGGLE;
            else if (idx == poll_idx && hit)
                s = SRC_POLL;
        end
        return s;
    endfunction

endpackage

// File: rtl/wsr_access_detect.sv
module wsr_access_detect
    import wsr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    ce_n,
    input  logic    oe_n,
    input  logic    we_n,
    output rd_evt_t evt
);

    logic rd_en;
    logic rd_en_q;

    assign rd_en = ~ce_n & ~oe_n & we_n;

    always_ff @(posedge clk) begin
        if (rst)
            rd_en_q <= 1'b0;
        else
            rd_en_q <= rd_en;
    end

    assign evt.en    = rd_en;
    assign evt.start = rd_en & ~rd_en_q;

    // R5: an access start lasts exactly one cycle
    a_r5_start_once: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> !evt.start);

    // R6: a write-enable-low cycle never opens an access
    a_r6_we_blocks_start: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> !evt.start);

endmodule

// File: rtl/wsr_toggle_track.sv
module wsr_toggle_track
    import wsr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    busy_i,
    input  rd_evt_t evt,
    output logic    tog_bit
);

    logic tog_q;

    always_ff @(posedge clk) begin
        if (rst)
            tog_q <= 1'b0;
        else if (busy_i && evt.start)
            tog_q <= ~tog_q;
    end

    // The new value is shown from the start cycle onward, so it is steady
    // for the whole access.
    assign tog_bit = tog_q ^ evt.start;

    // R4: every access started while busy flips the stored state
    a_r4_flip_per_access: assert property (@(posedge clk) disable iff (rst)
        (busy_i && evt.start) |=> (tog_q != $past(tog_q)));

    // R5: a continuing access leaves the state alone
    a_r5_hold_in_access: assert property (@(posedge clk) disable iff (rst)
        (evt.en && !evt.start) |=> $stable(tog_q));

    // R8: no change once programming is over
    a_r8_frozen_idle: assert property (@(posedge clk) disable iff (rst)
        !busy_i |=> $stable(tog_q));

endmodule

// File: rtl/wsr_status_mux.sv
module wsr_status_mux
    import wsr_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 19,
    parameter int POLL_BIT = 7,
    parameter int TOG_BIT  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  rd_evt_t           evt,
    input  logic              busy_i,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] last_addr,
    input  logic [DATA_W-1:0] last_data,
    input  logic [DATA_W-1:0] array_rdata,
    input  logic              tog_bit,
    output logic [DATA_W-1:0] dq_out
);

    logic              hit;
    logic [DATA_W-1:0] poll_vec;
    logic [DATA_W-1:0] dq_raw;

    assign hit      = (addr == last_addr);
    assign poll_vec = ~last_data;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        bit_src_e src;
        logic     b;
        always_comb begin
            src = pick_src(i, POLL_BIT, TOG_BIT, busy_i, hit);
            unique case (src)
                SRC_POLL:   b = poll_vec[i];
                SRC_TOGGLE: b = tog_bit;
                default:    b = array_rdata[i];
            endcase
        end
        assign dq_raw[i] = b;
    end

    assign dq_out = evt.en ? dq_raw : '0;

    // R1: quiet bus when no read is enabled
    a_r1_quiet_bus: assert property (@(posedge clk) disable iff (rst)
        !evt.en |-> (dq_out == '0));

    // R2: complement of the loaded top bit on the polled location
    a_r2_poll_complement: assert property (@(posedge clk) disable iff (rst)
        (busy_i && evt.en && addr == last_addr)
            |-> (dq_out[POLL_BIT] != last_data[POLL_BIT]));

    // R7: low bits pass through while busy
    a_r7_low_bits_pass: assert property (@(posedge clk) disable iff (rst)
        (busy_i && evt.en) |-> (dq_out[5:0] == array_rdata[5:0]));

    // R8: true data when idle
    a_r8_true_data: assert property (@(posedge clk) disable iff (rst)
        (!busy_i && evt.en) |-> (dq_out == array_rdata));

endmodule

// File: rtl/wr_status_readback.sv
module wr_status_readback
    import wsr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] array_rdata,
    input  logic              busy,
    input  logic [ADDR_W-1:0] last_addr,
    input  logic [DATA_W-1:0] last_data,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);

    localparam int POLL_BIT = DATA_W - 1;
    localparam int TOG_BIT  = DATA_W - 2;

    rd_evt_t evt;
    logic    tog_bit;

    wsr_access_detect u_detect (
        .clk  (clk),
        .rst  (rst),
        .ce_n (ce_n),
        .oe_n (oe_n),
        .we_n (we_n),
        .evt  (evt)
    );

    wsr_toggle_track u_toggle (
        .clk     (clk),
        .rst     (rst),
        .busy_i  (busy),
        .evt     (evt),
        .tog_bit (tog_bit)
    );

    wsr_status_mux #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .POLL_BIT (POLL_BIT),
        .TOG_BIT  (TOG_BIT)
    ) u_mux (
        .clk         (clk),
        .rst         (rst),
        .evt         (evt),
        .busy_i      (busy),
        .addr        (addr),
        .last_addr   (last_addr),
        .last_data   (last_data),
        .array_rdata (array_rdata),
        .tog_bit     (tog_bit),
        .dq_out      (dq_out)
    );

    assign dq_oe = evt.en;

    // R1: write enable low never drives the bus
    a_r1_we_blocks_drive: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> !dq_oe);

endmodule

// File: tb/wr_status_readback_tb_top.sv
module wr_status_readback_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        ce_n, oe_n, we_n;
    logic [18:0] addr, last_addr;
    logic [7:0]  array_rdata, last_data;
    logic        busy;
    logic [7:0]  dq_out;
    logic        dq_oe;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    wr_status_readback dut_i (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .array_rdata(array_rdata), .busy(busy),
        .last_addr(last_addr), .last_data(last_data),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic bus_idle();
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    endtask

    // One read access, opened by oe_n (use_ce=0) or by ce_n (use_ce=1)
    task automatic do_read(input logic use_ce, output logic [7:0] d);
        cyc();
        we_n = 1'b1;
        if (use_ce) begin oe_n = 1'b0; ce_n = 1'b0; end
        else        begin ce_n = 1'b0; oe_n = 1'b0; end
        @(negedge clk);
        d = dq_out;
        cyc();
        if (use_ce) ce_n = 1'b1; else oe_n = 1'b1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 reset oe", {7'd0, dq_oe}, 8'h00);
        check("R1 reset data", dq_out, 8'h00);
    endtask

    task automatic t_decode();
        busy = 1'b0; array_rdata = 8'h5A;
        for (int k = 0; k < 8; k++) begin
            cyc();
            {ce_n, oe_n, we_n} = 3'(k);
            @(negedge clk);
            check("R1 decode oe", {7'd0, dq_oe}, (k == 1) ? 8'h01 : 8'h00);
            check("R1 decode data", dq_out, (k == 1) ? 8'h5A : 8'h00);
        end
        cyc();
        bus_idle();
    endtask

    task automatic t_idle_read();
        logic [7:0] d;
        busy = 1'b0; array_rdata = 8'hC3; addr = 19'h00100; last_addr = 19'h00100;
        last_data = 8'h11;
        for (int k = 0; k < 3; k++) begin
            do_read(k[0], d);
            check("R8 idle true data", d, 8'hC3);
        end
    endtask

    task automatic t_poll_hit();
        logic [7:0] d;
        busy = 1'b1; addr = 19'h12345; last_addr = 19'h12345;
        last_data = 8'h7E; array_rdata = 8'h81;
        do_read(1'b0, d);
        check("R2 bit7 inverse of 0", {7'd0, d[7]}, 8'h01);
        check("R7 low bits", {2'd0, d[5:0]}, 8'h01);
        last_data = 8'h80; array_rdata = 8'h2A;
        do_read(1'b0, d);
        check("R2 bit7 inverse of 1", {7'd0, d[7]}, 8'h00);
        check("R7 low bits", {2'd0, d[5:0]}, 8'h2A);
    endtask

    task automatic t_poll_miss();
        logic [7:0] d;
        busy = 1'b1; addr = 19'h00042; last_addr = 19'h00043; last_data = 8'h00;
        array_rdata = 8'h80;
        do_read(1'b0, d);
        check("R3 miss bit7 array 1", {7'd0, d[7]}, 8'h01);
        array_rdata = 8'h15;
        do_read(1'b1, d);
        check("R3 miss bit7 array 0", {7'd0, d[7]}, 8'h00);
        check("R7 miss low bits", {2'd0, d[5:0]}, 8'h15);
    endtask

    task automatic t_toggle(input logic use_ce, input string tag);
        logic [7:0] d;
        logic       prev;
        busy = 1'b1; addr = 19'h00007; last_addr = 19'h00009; array_rdata = 8'h3F;
        do_read(use_ce, d);
        prev = d[6];
        for (int k = 0; k < 4; k++) begin
            do_read(use_ce, d);
            check(tag, {7'd0, d[6]}, {7'd0, ~prev});
            prev = d[6];
        end
    endtask

    task automatic t_long_read();
        logic [7:0] d;
        logic       first;
        busy = 1'b1; addr = 19'h00020; last_addr = 19'h00021; array_rdata = 8'h00;
        cyc();
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        @(negedge clk);
        first = dq_out[6];
        for (int k = 0; k < 6; k++) begin
            cyc();
            @(negedge clk);
            check("R5 steady in long access", {7'd0, dq_out[6]}, {7'd0, first});
        end
        cyc();
        bus_idle();
        do_read(1'b0, d);
        check("R4 after long access", {7'd0, d[6]}, {7'd0, ~first});
    endtask

    task automatic t_we_period();
        logic [7:0] d;
        logic       v;
        busy = 1'b1; addr = 19'h00030; last_addr = 19'h00031; array_rdata = 8'h00;
        do_read(1'b0, d);
        v = d[6];
        cyc();
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        check("R1 we low no drive", {7'd0, dq_oe}, 8'h00);
        cyc();
        cyc();
        bus_idle();
        do_read(1'b0, d);
        check("R6 we period not an access", {7'd0, d[6]}, {7'd0, ~v});
    endtask

    task automatic t_late_poll();
        busy = 1'b0; addr = 19'h00500; last_addr = 19'h00500;
        last_data = 8'h00; array_rdata = 8'h01;
        cyc();
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        @(negedge clk);
        check("R8 before busy", dq_out, 8'h01);
        cyc();
        busy = 1'b1;
        @(negedge clk);
        check("R9 poll inside open access", {7'd0, dq_out[7]}, 8'h01);
        check("R7 low bits inside open access", {2'd0, dq_out[5:0]}, 8'h01);
        cyc();
        bus_idle();
    endtask

    task automatic t_done();
        logic [7:0] d;
        busy = 1'b1; addr = 19'h00600; last_addr = 19'h00600;
        last_data = 8'hFF; array_rdata = 8'hFF;
        do_read(1'b0, d);
        check("R2 busy poll", {7'd0, d[7]}, 8'h00);
        cyc();
        busy = 1'b0;
        for (int k = 0; k < 3; k++) begin
            do_read(k[0], d);
            check("R8 done full data", d, 8'hFF);
        end
        array_rdata = 8'h40;
        do_read(1'b0, d);
        check("R8 done bit6 true", d, 8'h40);
    endtask

    initial begin
        #(200000 * 4);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        bus_idle();
        busy = 1'b0; addr = '0; last_addr = '0; last_data = '0; array_rdata = '0;
        repeat (3) cyc();
        rst = 1'b0;
        t_reset();
        t_decode();
        t_idle_read();
        t_poll_hit();
        t_poll_miss();
        t_toggle(1'b0, "R4 alternation via oe_n");
        t_toggle(1'b1, "R6 alternation via ce_n");
        t_long_read();
        t_we_period();
        t_late_poll();
        t_done();
        repeat (2) cyc();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule